// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This block is a small accelerator for cyclic redundancy checks and the 16-bit ones'-complement checksum used in internet protocols. Software, or any other bus master, programs a control word that picks the operation and the pre- and post-processing. It then writes data words one at a time. Each write to the data register folds the word, or only its low byte, into a running context within a single clock. The context can be read back, or reloaded to save and restore a computation. A separate read address returns the context after output reversal and inversion, ready to use as a finished check value.

There are four polynomials: two 16-bit (0x8005, 0x1021) and two 32-bit (0x04C11DB7, 0x1EDC6F41). The checksum is a fifth mode. The input path can reorder the four bytes of a word and mirror the bits of each byte. Together with output mirroring and inversion, this covers both reflected and non-reflected CRC variants.

Top module: `crc_engine`

## Requirements
- R1: After reset, the control register (offset 0x400) and the context register (offset 0x410) both read zero.
- R2: A write to offset 0x410 loads the context with the written word, whatever the init field holds. The new value is readable on the next cycle.
- R3: A control write stores the word, which reads back masked to 0x000073BF. Its init field, bits [14:13], then acts on the context: 10 clears it, 11 sets it to all ones, and 00 or 01 leaves it unchanged.
- R4: Type field bits [3:0] = 2 selects polynomial 0x04C11DB7 and 3 selects 0x1EDC6F41. Both are 32-bit CRCs, with data fed most significant bit first and no implicit final step.
- R5: Type 0 (poly 0x8005) and type 1 (poly 0x1021) are 16-bit CRCs on context bits [15:0]. Every data write in these modes leaves context bits [31:16] at zero.
- R6: Field bits [5:4] reorders the input bytes B3..B0 (B3 = bits [31:24]) into the order fed, most significant first: 00 B3,B2,B1,B0; 01 B2,B3,B0,B1; 10 B1,B0,B3,B2; 11 B0,B1,B2,B3.
- R7: Bit 7 mirrors the bit order inside each input byte after reordering.
- R8: When bit 12 is set, a data write consumes only bits [7:0] as a single byte, and the byte-order field has no effect. When bit 12 is clear, all 32 bits are consumed.
- R9: Type 8 adds the high and then the low 16-bit half of the word into a 16-bit ones'-complement sum with end-around carry. In byte mode it adds the byte, zero-extended.
- R10: The result register (offset 0x418) holds the context masked to the mode width: 16 bits for types 0, 1 and 8, and 32 bits otherwise. Bit 8 mirrors it within that width, then bit 9 inverts it within that width.
- R11: For a type code other than 0, 1, 2, 3 or 8, data writes leave the context unchanged.
- R12: Writes to the result offset or to unmapped offsets change neither the control register nor the context. Reads of the data offset and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr and registered state |

## Verification
A wrong context bit comes out on the very next read of the context offset. It cannot heal itself, because every later data write feeds the bad bit forward, so a wrong intermediate state stays visible until the context is reloaded. Errors in byte ordering or in bit mirroring change the context after the first affected data write. Errors in output processing appear only at the result offset, in the same cycle as the state they come from. Known check values for the standard CRC variants and for an IP header pin down the absolute behaviour. A sweep over every operation and every processing flag, against an arithmetic model, catches mode-specific slips.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int DW    = 32;
    localparam int AW    = 12;
    localparam int NLANE = 4;
    localparam int NBYTE = DW / 8;

    localparam logic [AW-1:0] OFS_CTRL = AW'('h400);
    localparam logic [AW-1:0] OFS_CTX  = AW'('h410);
    localparam logic [AW-1:0] OFS_DATA = AW'('h414);
    localparam logic [AW-1:0] OFS_RES  = AW'('h418);

    localparam logic [3:0] OP_CSUM = 4'd8;
    localparam logic [DW-1:0] CTRL_KEEP = 32'h0000_73BF;

    typedef struct packed {
        logic [1:0] init_sel;
        logic       byte_mode;
        logic       inv_out;
        logic       rev_out;
        logic       rev_in;
        logic [1:0] swap;
        logic [3:0] op;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [DW-1:0] w);
        ctrl_t c;
        c.init_sel  = w[14:13];
        c.byte_mode = w[12];
        c.inv_out   = w[9];
        c.rev_out   = w[8];
        c.rev_in    = w[7];
        c.swap      = w[5:4];
        c.op        = w[3:0];
        return c;
    endfunction

    function automatic logic [DW-1:0] ctrl_to_word(ctrl_t c);
        logic [DW-1:0] w;
        w        = '0;
        w[14:13] = c.init_sel;
        w[12]    = c.byte_mode;
        w[9]     = c.inv_out;
        w[8]     = c.rev_out;
        w[7]     = c.rev_in;
        w[5:4]   = c.swap;
        w[3:0]   = c.op;
        return w;
    endfunction

    function automatic logic op_is_crc(logic [3:0] op);
        return op[3:2] == 2'b00;
    endfunction

    function automatic logic op_is16(logic [3:0] op);
        return (op == 4'd0) || (op == 4'd1) || (op == OP_CSUM);
    endfunction

    function automatic logic [31:0] lane_poly(int g);
        case (g)
            0:       return 32'h0000_8005;
            1:       return 32'h0000_1021;
            2:       return 32'h04C1_1DB7;
            default: return 32'h1EDC_6F41;
        endcase
    endfunction

    function automatic logic [7:0] mirror8(logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [DW-1:0] mirror32(logic [DW-1:0] v);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
        return r;
    endfunction

    // Shift nbits of data (left aligned) into ctx, MSB first, width 16 or 32.
    function automatic logic [DW-1:0] crc_shift(logic [DW-1:0] ctx, logic [DW-1:0] data,
                                                int nbits, logic [DW-1:0] poly, int width);
        logic [DW-1:0] c;
        logic          fb;
        c = ctx;
        for (int i = 0; i < DW; i++) begin
            if (i < nbits) begin
                fb = ((width == 16) ? c[15] : c[DW-1]) ^ data[DW-1-i];
                c  = c << 1;
                if (fb) c = c ^ poly;
            end
        end
        if (width == 16) c[DW-1:16] = '0;
        return c;
    endfunction

    function automatic logic [15:0] ones_add(logic [15:0] a, logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction
endpackage

// File: rtl/crc_in_cond.sv
module crc_in_cond
    import crc_pkg::*;
(
    input  logic [DW-1:0] raw,
    input  logic [1:0]    swap,
    input  logic          rev_in,
    input  logic          byte_mode,
    output logic [DW-1:0] fed
);
    logic [DW-1:0] word_fed;

    // Destination byte k takes source byte k xor swap: covers all four orderings.
    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        logic [1:0] src;
        logic [7:0] pick;
        assign src  = 2'(k) ^ swap;
        assign pick = raw[8*src +: 8];
        assign word_fed[8*k +: 8] = rev_in ? mirror8(pick) : pick;
    end

    always_comb begin
        if (byte_mode)
            fed = {(rev_in ? mirror8(raw[7:0]) : raw[7:0]), 24'd0};
        else
            fed = word_fed;
    end
endmodule

// File: rtl/crc_core.sv
module crc_core
    import crc_pkg::*;
(
    input  logic [DW-1:0] ctx,
    input  logic [DW-1:0] fed,
    input  logic          byte_mode,
    input  logic [3:0]    op,
    output logic [DW-1:0] ctx_nxt
);
    logic [DW-1:0] lane [NLANE];
    logic [15:0]   sum;
    int            nbits;

    assign nbits = byte_mode ? 8 : DW;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g < 2) ? 16 : 32;
        assign lane[g] = crc_shift(ctx, fed, nbits, lane_poly(g), LW);
    end

    always_comb begin
        if (byte_mode)
            sum = ones_add(ctx[15:0], {8'd0, fed[31:24]});
        else
            sum = ones_add(ones_add(ctx[15:0], fed[31:16]), fed[15:0]);
    end

    always_comb begin
        if (op_is_crc(op))
            ctx_nxt = lane[op[1:0]];
        else if (op == OP_CSUM)
            ctx_nxt = {16'd0, sum};
        else
            ctx_nxt = ctx;
    end
endmodule

// File: rtl/crc_post.sv
module crc_post
    import crc_pkg::*;
(
    input  logic [DW-1:0] ctx,
    input  logic [3:0]    op,
    input  logic          rev_out,
    input  logic          inv_out,
    output logic [DW-1:0] res
);
    logic          narrow;
    logic [DW-1:0] masked;
    logic [DW-1:0] flipped;
    logic [DW-1:0] wmask;

    assign narrow = op_is16(op);
    assign wmask  = narrow ? 32'h0000_FFFF : '1;
    assign masked = ctx & wmask;

    always_comb begin
        if (!rev_out)
            flipped = masked;
        else if (narrow)
            flipped = mirror32(masked) >> 16;
        else
            flipped = mirror32(masked);
        res = inv_out ? (flipped ^ wmask) : flipped;
    end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_wr;
    logic [DW-1:0] ctx_q;
    logic [DW-1:0] fed;
    logic [DW-1:0] ctx_nxt;
    logic [DW-1:0] res;

    assign ctrl_wr = ctrl_from_word(wr_data);

    crc_in_cond u_in (
        .raw       (wr_data),
        .swap      (ctrl_q.swap),
        .rev_in    (ctrl_q.rev_in),
        .byte_mode (ctrl_q.byte_mode),
        .fed       (fed)
    );

    crc_core u_core (
        .ctx       (ctx_q),
        .fed       (fed),
        .byte_mode (ctrl_q.byte_mode),
        .op        (ctrl_q.op),
        .ctx_nxt   (ctx_nxt)
    );

    crc_post u_post (
        .ctx     (ctx_q),
        .op      (ctrl_q.op),
        .rev_out (ctrl_q.rev_out),
        .inv_out (ctrl_q.inv_out),
        .res     (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ctx_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFS_CTRL: begin
                    ctrl_q <= ctrl_wr;
                    if (ctrl_wr.init_sel == 2'b10) ctx_q <= '0;
                    else if (ctrl_wr.init_sel == 2'b11) ctx_q <= '1;
                end
                OFS_CTX:  ctx_q <= wr_data;
                OFS_DATA: ctx_q <= ctx_nxt;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            OFS_CTRL: rd_data = ctrl_to_word(ctrl_q);
            OFS_CTX:  rd_data = ctx_q;
            OFS_RES:  rd_data = res;
            default:  rd_data = '0;
        endcase
    end

    // R2
    ctx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_CTX) |=> (ctx_q == $past(wr_data)));

    // R3
    init_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_CTRL && wr_data[14:13] == 2'b10) |=> (ctx_q == '0));

    // R5
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_DATA && (ctrl_q.op == 4'd0 || ctrl_q.op == 4'd1))
        |=> (ctx_q[31:16] == 16'd0));

    // R11
    undef_op_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_DATA && ctrl_q.op != OP_CSUM && ctrl_q.op[3:2] != 2'b00)
        |=> $stable(ctx_q));

    // R12
    dead_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != OFS_CTRL && wr_addr != OFS_CTX && wr_addr != OFS_DATA)
        |=> ($stable(ctx_q) && $stable(ctrl_q)));
endmodule

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
    localparam logic [11:0] A_CTRL = 12'h400;
    localparam logic [11:0] A_CTX  = 12'h410;
    localparam logic [11:0] A_DATA = 12'h414;
    localparam logic [11:0] A_RES  = 12'h418;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    crc_engine dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // ---- arithmetic reference model ----
    function automatic logic [31:0] m_order(input logic [31:0] w, input logic [1:0] m);
        case (m)
            2'd0: return w;
            2'd1: return {w[23:16], w[31:24], w[7:0], w[15:8]};
            2'd2: return {w[15:8], w[7:0], w[31:24], w[23:16]};
            default: return {w[7:0], w[15:8], w[23:16], w[31:24]};
        endcase
    endfunction

    function automatic logic [7:0] m_flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    function automatic logic [31:0] m_step(input logic [31:0] ctx, input logic [31:0] ctl,
                                           input logic [31:0] w);
        logic [31:0] s;
        logic [31:0] c;
        logic [31:0] p;
        int          n;
        int          wd;
        int          t;
        logic [16:0] acc;
        t = int'(ctl[3:0]);
        if (ctl[12]) begin
            s = {(ctl[7] ? m_flip8(w[7:0]) : w[7:0]), 24'd0};
            n = 8;
        end else begin
            s = m_order(w, ctl[5:4]);
            if (ctl[7]) s = {m_flip8(s[31:24]), m_flip8(s[23:16]), m_flip8(s[15:8]), m_flip8(s[7:0])};
            n = 32;
        end
        if (t == 8) begin
            acc = {1'b0, ctx[15:0]};
            if (n == 8) begin
                acc = acc + {9'd0, s[31:24]};
                acc = {1'b0, acc[15:0]} + {16'd0, acc[16]};
            end else begin
                acc = acc + {1'b0, s[31:16]};
                acc = {1'b0, acc[15:0]} + {16'd0, acc[16]};
                acc = acc + {1'b0, s[15:0]};
                acc = {1'b0, acc[15:0]} + {16'd0, acc[16]};
            end
            return {16'd0, acc[15:0]};
        end
        if (t > 3) return ctx;
        case (t)
            0: begin p = 32'h8005; wd = 16; end
            1: begin p = 32'h1021; wd = 16; end
            2: begin p = 32'h04C11DB7; wd = 32; end
            default: begin p = 32'h1EDC6F41; wd = 32; end
        endcase
        c = (wd == 16) ? {16'd0, ctx[15:0]} : ctx;
        for (int i = 0; i < n; i++) begin
            if (c[wd-1] ^ s[31-i]) c = (c << 1) ^ p;
            else c = c << 1;
            if (wd == 16) c = c & 32'h0000FFFF;
        end
        return c;
    endfunction

    function automatic logic [31:0] m_post(input logic [31:0] ctx, input logic [31:0] ctl);
        int          t;
        int          wd;
        logic [31:0] v;
        logic [31:0] r;
        logic [31:0] mk;
        t  = int'(ctl[3:0]);
        wd = (t == 0 || t == 1 || t == 8) ? 16 : 32;
        mk = (wd == 16) ? 32'h0000FFFF : 32'hFFFFFFFF;
        v  = ctx & mk;
        if (ctl[8]) begin
            r = '0;
            for (int i = 0; i < wd; i++) r[wd-1-i] = v[i];
            v = r;
        end
        if (ctl[9]) v = v ^ mk;
        return v;
    endfunction

    task automatic feed_digits();
        for (int i = 0; i < 9; i++) wr(A_DATA, 32'h31 + i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] seed;
        logic [31:0] ctl;
        logic [31:0] mc;
        logic [31:0] d;
        logic [31:0] ops [6];
        logic [1:0]  initv [3];
        string       tg;
        ops   = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd8, 32'd5};
        initv = '{2'b00, 2'b10, 2'b11};
        d = 32'h1357_9BDF;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(A_CTX, v);  chk("R1 ctx after reset", v, 32'h0);

        // R3 readback mask and all-ones init
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R3 ctrl readback mask", v, 32'h0000_73BF);
        rd(A_CTX, v);  chk("R3 init all ones", v, 32'hFFFF_FFFF);
        // R2 seed load wins over init mode
        wr(A_CTX, 32'hCAFE_F00D);
        rd(A_CTX, v);  chk("R2 seed load", v, 32'hCAFE_F00D);
        // R3 init 00 and 01 keep the context
        wr(A_CTRL, 32'h0000_0002);
        rd(A_CTX, v);  chk("R3 init 00 keeps", v, 32'hCAFE_F00D);
        wr(A_CTRL, 32'h0000_2002);
        rd(A_CTX, v);  chk("R3 init 01 keeps", v, 32'hCAFE_F00D);
        wr(A_CTRL, 32'h0000_4002);
        rd(A_CTX, v);  chk("R3 init zeros", v, 32'h0);

        // R12 dead writes and zero reads
        wr(A_CTX, 32'h0BAD_BEEF);
        wr(A_RES, 32'h1111_2222);
        wr(12'h000, 32'h3333_4444);
        wr(12'h41C, 32'h5555_6666);
        rd(A_CTX, v);  chk("R12 ctx untouched", v, 32'h0BAD_BEEF);
        rd(A_CTRL, v); chk("R12 ctrl untouched", v, 32'h0000_4002);
        rd(A_DATA, v); chk("R12 data reads zero", v, 32'h0);
        rd(12'h000, v); chk("R12 unmapped reads zero", v, 32'h0);

        // R11 undefined op
        wr(A_CTRL, 32'h0000_0005);
        wr(A_DATA, 32'h1234_5678);
        rd(A_CTX, v);  chk("R11 undefined op keeps ctx", v, 32'h0BAD_BEEF);

        // Known check values over ASCII 1..9 in byte mode (R8)
        wr(A_CTRL, 32'h0000_7002); feed_digits();
        rd(A_RES, v);  chk("R4 R8 poly 04C11DB7 plain", v, 32'h0376_E6E7);
        wr(A_CTRL, 32'h0000_7382); feed_digits();
        rd(A_RES, v);  chk("R7 R10 poly 04C11DB7 reflected", v, 32'hCBF4_3926);
        wr(A_CTRL, 32'h0000_7383); feed_digits();
        rd(A_RES, v);  chk("R4 R7 R10 poly 1EDC6F41 reflected", v, 32'hE306_9283);
        wr(A_CTRL, 32'h0000_5001); feed_digits();
        rd(A_RES, v);  chk("R5 poly 1021", v, 32'h0000_31C3);
        wr(A_CTRL, 32'h0000_5000); feed_digits();
        rd(A_RES, v);  chk("R5 poly 8005", v, 32'h0000_FEE8);

        // R9 header checksum
        wr(A_CTRL, 32'h0000_4208);
        wr(A_DATA, 32'h4500_0073);
        wr(A_DATA, 32'h0000_4000);
        wr(A_DATA, 32'h4011_0000);
        wr(A_DATA, 32'hC0A8_0001);
        wr(A_DATA, 32'hC0A8_00C7);
        rd(A_RES, v);  chk("R9 header checksum", v, 32'h0000_B861);

        // Sweep: every op, byte order (R6), input mirror (R7), size (R8),
        // output mirror and inversion (R10), with assorted init sources (R3).
        for (int oi = 0; oi < 6; oi++) begin
            for (int e = 0; e < 4; e++) begin
                for (int f = 0; f < 16; f++) begin
                    d = d * 32'd1664525 + 32'd1013904223;
                    seed = d;
                    ctl = ops[oi] | (32'(e) << 4) | (32'(f & 1) << 7) | (32'((f >> 1) & 1) << 12)
                        | (32'((f >> 2) & 1) << 8) | (32'((f >> 3) & 1) << 9)
                        | (32'(initv[(e + f) % 3]) << 13);
                    wr(A_CTX, seed);
                    wr(A_CTRL, ctl);
                    case (ctl[14:13])
                        2'b10: mc = 32'h0;
                        2'b11: mc = 32'hFFFF_FFFF;
                        default: mc = seed;
                    endcase
                    for (int k = 0; k < 3; k++) begin
                        d = d * 32'd1664525 + 32'd1013904223;
                        wr(A_DATA, d);
                        mc = m_step(mc, ctl, d);
                    end
                    case (oi)
                        0, 1: tg = "R5 R6 R7 R8";
                        2, 3: tg = "R4 R6 R7 R8";
                        4: tg = "R9 R6 R7 R8";
                        default: tg = "R11";
                    endcase
                    rd(A_CTX, v);
                    chk($sformatf("%s ctx op%0d ord%0d f%0d", tg, ops[oi], e, f), v, mc);
                    rd(A_RES, v);
                    chk($sformatf("R10 result op%0d ord%0d f%0d", ops[oi], e, f), v, m_post(mc, ctl));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule